// File: doc/BRIEF.md
# Paired 8-bit Counter Timer with Pulse and PWM Output

This block holds two 8-bit up-counters that run on clock-enable ticks and share one 2-bit operating mode. It can act as two separate interval timers, with the second counter optionally counting the period completions of the first. It can also act as one 16-bit interval timer built from both counters, as a programmable pulse generator whose output edges are set by two thresholds, or as an 8-bit pulse-width modulator. In the modulator mode a write to the first threshold can be held back and applied at the period boundary.

A single output flip-flop drives the timer pin. Hardware events move it, and a write command can also invert, set or clear it. Each channel reports a compare match as a single-cycle interrupt pulse. The tick sources come from an external prescaler. Registers are loaded through plain write strobes that share one data bus.

Top module: `tmr_pair8`

## Requirements
- R1: `mode_in` is decoded as 00 = two separate timers, 01 = one 16-bit timer, 10 = pulse generator, 11 = PWM. A `mode_wr` pulse is applied only when `run0` and `run1` are both low; otherwise it is ignored. After reset the mode is 00.
- R2: In mode 00, each enabled tick advances counter 0. When the advanced value equals `cmp0`, the counter returns to 0 and `irq0` is high for the following cycle. The interrupt period is therefore `cmp0` ticks, and `cmp0` = 0 gives 256 ticks.
- R3: In mode 00 with `chain1` high, counter 1 advances once for each counter-0 match instead of on `tick1`. Its interrupt `irq1` then repeats every `cmp0`×`cmp1` ticks of `tick0`.
- R4: In mode 01, `{cnt1,cnt0}` advances on `tick0` while `run0` is high (`run1` is ignored). It is compared with `{cmp1,cmp0}`. A match clears both counters and pulses only `irq1`; `irq0` stays low.
- R5: In mode 10, the output flip-flop inverts when the advanced counter 0 equals `cmp0` and again when it equals `cmp1`. The match with `cmp1` also clears the counter. `irq0` pulses on both matches and `irq1` never pulses.
- R6: In mode 11, counter 0 wraps freely. The output flip-flop goes to 1 when the counter wraps from 255 to 0 and goes to 0 on a match with `cmp0`; the wrap wins if both occur on one edge. `irq0` pulses on the match and `irq1` never pulses.
- R7: A `ff_wr` pulse applies `ff_cmd` to the output flip-flop: 00 inverts it, 01 sets it, 10 clears it, 11 leaves it unchanged. The command overrides any hardware event on the same edge.
- R8: With `dbuf_en` low, a `wr_cmp0` write loads `cmp0` at once. With `dbuf_en` high, the write goes to a holding register, which is copied into `cmp0` on the next PWM wrap.
- R9: While `run0` (or, in mode 00, `run1`) is low, the corresponding counter is held at 0, so a restart begins a full period.
- R10: In mode 00 the output flip-flop inverts on every counter-1 match, and in mode 01 on every 16-bit match.
- R11: After reset, `irq0`, `irq1` and `tout` are 0 and both thresholds are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick0 | input | 1 | Count enable for counter 0 |
| tick1 | input | 1 | Count enable for counter 1 in mode 00 |
| chain1 | input | 1 | Counter 1 counts counter-0 matches |
| run0 | input | 1 | Run enable, counter 0 (and 16-bit pair) |
| run1 | input | 1 | Run enable, counter 1 in mode 00 |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 2 | Mode value |
| wr_cmp0 | input | 1 | Threshold 0 write strobe |
| wr_cmp1 | input | 1 | Threshold 1 write strobe |
| wr_data | input | 8 | Threshold write data |
| dbuf_en | input | 1 | Defer threshold 0 writes to the PWM wrap |
| ff_wr | input | 1 | Output flip-flop command strobe |
| ff_cmd | input | 2 | Output flip-flop command |
| irq0 | output | 1 | Channel 0 match pulse |
| irq1 | output | 1 | Channel 1 match pulse |
| tout | output | 1 | Timer output flip-flop |

## Verification
The bench measures intervals in ticks between interrupt pulses and output edges at the threshold extremes, including a threshold of 0, which must give a full 256-tick period; a design that compares the old count would instead lose a tick or stall. It restarts a stopped counter and expects a full period, which catches a counter that only freezes. It writes a mode while running and checks that the old behaviour continues. In PWM mode it writes a new threshold mid-period with the holding register enabled and then disabled. An immediate load where a deferred one is required shows up as a wrong high time in the current period.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

    typedef enum logic [1:0] {
        MD_SPLIT = 2'b00,
        MD_WIDE  = 2'b01,
        MD_PPG   = 2'b10,
        MD_PWM   = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        FF_FLIP = 2'b00,
        FF_SET  = 2'b01,
        FF_CLR  = 2'b10,
        FF_HOLD = 2'b11
    } ff_cmd_e;

    typedef struct packed {
        logic split0;
        logic split1;
        logic wide;
        logic ppg_lo;
        logic ppg_hi;
        logic pwm_hit;
        logic pwm_wrap;
    } tmr_evt_t;

    function automatic logic apply_cmd(input ff_cmd_e c, input logic cur);
        case (c)
            FF_FLIP: return ~cur;
            FF_SET:  return 1'b1;
            FF_CLR:  return 1'b0;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/tmr_cfg.sv
module tmr_cfg
    import tmr_pair_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run0,
    input  logic         run1,
    input  logic         mode_wr,
    input  tmr_mode_e    mode_in,
    input  logic         wr_cmp0,
    input  logic         wr_cmp1,
    input  logic [W-1:0] wr_data,
    input  logic         dbuf_en,
    input  logic         pwm_wrap,
    output tmr_mode_e    mode,
    output logic [W-1:0] cmp0,
    output logic [W-1:0] cmp1
);
    tmr_mode_e    mode_q;
    logic [W-1:0] cmp0_q, cmp1_q, hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_SPLIT;
            cmp0_q <= '0;
            cmp1_q <= '0;
            hold_q <= '0;
        end else begin
            if (mode_wr && !run0 && !run1)
                mode_q <= mode_in;
            if (wr_cmp1)
                cmp1_q <= wr_data;
            if (wr_cmp0) begin
                if (dbuf_en) hold_q <= wr_data;
                else         cmp0_q <= wr_data;
            end
            if (dbuf_en && pwm_wrap)
                cmp0_q <= hold_q;
        end
    end

    assign mode = mode_q;
    assign cmp0 = cmp0_q;
    assign cmp1 = cmp1_q;

    // R1: a mode write while either channel runs has no effect
    assert_mode_locked_R1: assert property (@(posedge clk) disable iff (rst)
        (run0 || run1) |=> $stable(mode_q));

    // R8: a deferred write leaves the active threshold untouched
    assert_dbuf_defer_R8: assert property (@(posedge clk) disable iff (rst)
        (dbuf_en && wr_cmp0 && !pwm_wrap) |=> $stable(cmp0_q));

endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pair_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  tmr_mode_e    mode,
    input  logic         run0,
    input  logic         run1,
    input  logic         tick0,
    input  logic         tick1,
    input  logic         chain1,
    input  logic [W-1:0] cmp0,
    input  logic [W-1:0] cmp1,
    output tmr_evt_t     evt,
    output logic         irq0,
    output logic         irq1
);
    localparam int WW = 2 * W;

    logic [W-1:0]  c0_q, c1_q, c0_d, c1_d, n0, n1;
    logic [WW-1:0] n16, lim16;
    logic          en0, en1;
    logic          s0, s1, wd, plo, phi, mhit, mwrap;
    logic          irq0_q, irq1_q;

    assign n0    = c0_q + W'(1);
    assign n1    = c1_q + W'(1);
    assign n16   = {c1_q, c0_q} + WW'(1);
    assign lim16 = {cmp1, cmp0};
    assign en0   = run0 && tick0;

    always_comb begin
        s0 = 1'b0; s1 = 1'b0; wd = 1'b0; plo = 1'b0; phi = 1'b0;
        mhit = 1'b0; mwrap = 1'b0; en1 = 1'b0;
        c0_d = c0_q;
        c1_d = c1_q;
        case (mode)
            MD_SPLIT: begin
                s0  = en0 && (n0 == cmp0);
                en1 = run1 && (chain1 ? s0 : tick1);
                s1  = en1 && (n1 == cmp1);
                if (en0) c0_d = s0 ? '0 : n0;
                if (en1) c1_d = s1 ? '0 : n1;
            end
            MD_WIDE: begin
                wd = en0 && (n16 == lim16);
                if (en0) {c1_d, c0_d} = wd ? '0 : n16;
            end
            MD_PPG: begin
                plo = en0 && (n0 == cmp0);
                phi = en0 && (n0 == cmp1);
                if (en0) c0_d = phi ? '0 : n0;
                c1_d = '0;
            end
            default: begin
                mhit  = en0 && (n0 == cmp0);
                mwrap = en0 && (c0_q == '1);
                if (en0) c0_d = n0;
                c1_d = '0;
            end
        endcase
        if (!run0) begin
            c0_d = '0;
            if (mode != MD_SPLIT) c1_d = '0;
        end
        if (!run1 && mode == MD_SPLIT) c1_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c0_q   <= '0;
            c1_q   <= '0;
            irq0_q <= 1'b0;
            irq1_q <= 1'b0;
        end else begin
            c0_q   <= c0_d;
            c1_q   <= c1_d;
            irq0_q <= s0 || plo || phi || mhit;
            irq1_q <= s1 || wd;
        end
    end

    assign evt  = '{split0: s0, split1: s1, wide: wd, ppg_lo: plo,
                    ppg_hi: phi, pwm_hit: mhit, pwm_wrap: mwrap};
    assign irq0 = irq0_q;
    assign irq1 = irq1_q;

    // R9: a stopped channel sits at zero
    assert_stop_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !run0 |=> (c0_q == '0));

    // R2: the interrupt cycle follows the clearing edge
    assert_irq_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (irq0_q && mode == MD_SPLIT) |-> (c0_q == '0));

    // R5: channel 1 is silent in pulse and PWM modes
    assert_no_irq1_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_PPG || mode == MD_PWM) |-> !irq1_q);

    // R4: only the combined match interrupts in 16-bit mode
    assert_wide_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MD_WIDE) |-> !irq0_q);

endmodule

// File: rtl/tmr_outff.sv
module tmr_outff
    import tmr_pair_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tmr_evt_t evt,
    input  logic     cmd_wr,
    input  ff_cmd_e  cmd,
    output logic     q
);
    logic q_q, q_d, flip;

    assign flip = evt.split1 || evt.wide || (evt.ppg_lo ^ evt.ppg_hi);

    always_comb begin
        q_d = q_q;
        if (flip)              q_d = ~q_q;
        if (evt.pwm_wrap)      q_d = 1'b1;
        else if (evt.pwm_hit)  q_d = 1'b0;
        if (cmd_wr)            q_d = apply_cmd(cmd, q_q);
    end

    always_ff @(posedge clk) begin
        if (rst) q_q <= 1'b0;
        else     q_q <= q_d;
    end

    assign q = q_q;

    // R7: set and clear commands land on the next edge
    assert_cmd_set_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd == FF_SET) |=> q_q);
    assert_cmd_clr_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd == FF_CLR) |=> !q_q);

    // R6: a PWM wrap raises the output
    assert_pwm_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.pwm_wrap && !cmd_wr) |=> q_q);

endmodule

// File: rtl/tmr_pair8.sv
module tmr_pair8
    import tmr_pair_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick0,
    input  logic         tick1,
    input  logic         chain1,
    input  logic         run0,
    input  logic         run1,
    input  logic         mode_wr,
    input  logic [1:0]   mode_in,
    input  logic         wr_cmp0,
    input  logic         wr_cmp1,
    input  logic [W-1:0] wr_data,
    input  logic         dbuf_en,
    input  logic         ff_wr,
    input  logic [1:0]   ff_cmd,
    output logic         irq0,
    output logic         irq1,
    output logic         tout
);
    tmr_mode_e    mode;
    logic [W-1:0] cmp0, cmp1;
    tmr_evt_t     evt;

    tmr_cfg #(.W(W)) u_cfg (
        .clk(clk), .rst(rst), .run0(run0), .run1(run1),
        .mode_wr(mode_wr), .mode_in(tmr_mode_e'(mode_in)),
        .wr_cmp0(wr_cmp0), .wr_cmp1(wr_cmp1), .wr_data(wr_data),
        .dbuf_en(dbuf_en), .pwm_wrap(evt.pwm_wrap),
        .mode(mode), .cmp0(cmp0), .cmp1(cmp1)
    );

    tmr_count #(.W(W)) u_count (
        .clk(clk), .rst(rst), .mode(mode), .run0(run0), .run1(run1),
        .tick0(tick0), .tick1(tick1), .chain1(chain1),
        .cmp0(cmp0), .cmp1(cmp1), .evt(evt), .irq0(irq0), .irq1(irq1)
    );

    tmr_outff u_outff (
        .clk(clk), .rst(rst), .evt(evt), .cmd_wr(ff_wr),
        .cmd(ff_cmd_e'(ff_cmd)), .q(tout)
    );

endmodule

// File: tb/tmr_pair8_bench.sv
module tmr_pair8_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick0 = 1'b1, tick1 = 1'b1, chain1 = 1'b0;
    logic run0 = 1'b0, run1 = 1'b0;
    logic mode_wr = 1'b0, wr_cmp0 = 1'b0, wr_cmp1 = 1'b0;
    logic [1:0] mode_in = 2'b00, ff_cmd = 2'b11;
    logic [7:0] wr_data = 8'd0;
    logic dbuf_en = 1'b0, ff_wr = 1'b0;
    logic irq0, irq1, tout;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    tmr_pair8 u_tmr_pair8 (
        .clk(clk), .rst(rst), .tick0(tick0), .tick1(tick1), .chain1(chain1),
        .run0(run0), .run1(run1), .mode_wr(mode_wr), .mode_in(mode_in),
        .wr_cmp0(wr_cmp0), .wr_cmp1(wr_cmp1), .wr_data(wr_data),
        .dbuf_en(dbuf_en), .ff_wr(ff_wr), .ff_cmd(ff_cmd),
        .irq0(irq0), .irq1(irq1), .tout(tout)
    );

    task automatic push(input string tag, input int v);
        tag_q.push_back(tag);
        exp_q.push_back(v);
    endtask

    task automatic pop_cmp(input int act);
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (act != e) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, e);
        end
    endtask

    function automatic logic sig(input int sel);
        if (sel == 0) return irq0;
        if (sel == 1) return irq1;
        return tout;
    endfunction

    task automatic meas(input int sel, input logic lvl, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sig(sel) != lvl && n < 3000);
        if (sig(sel) != lvl) n = -1;
    endtask

    task automatic step(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_in = m; mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic wc0(input logic [7:0] v);
        wr_data = v; wr_cmp0 = 1'b1;
        @(negedge clk);
        wr_cmp0 = 1'b0;
    endtask

    task automatic wc1(input logic [7:0] v);
        wr_data = v; wr_cmp1 = 1'b1;
        @(negedge clk);
        wr_cmp1 = 1'b0;
    endtask

    task automatic ffc(input logic [1:0] c, input int exp_lvl, input string tag);
        ff_cmd = c; ff_wr = 1'b1;
        push(tag, exp_lvl);
        @(negedge clk);
        ff_wr = 1'b0;
        pop_cmp(int'(tout));
    endtask

    task automatic gap(input int sel, input int e, input string tag);
        int n;
        push(tag, e);
        meas(sel, sel == 2 ? ~tout : 1'b1, n);
        pop_cmp(n);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n, cnt0;
        step(3);
        rst = 1'b0;
        step(1);
        // R11 reset state
        push("R11 irq0", 0); pop_cmp(int'(irq0));
        push("R11 irq1", 0); pop_cmp(int'(irq1));
        push("R11 tout", 0); pop_cmp(int'(tout));

        // R2 period equals threshold
        wc0(8'd5);
        run0 = 1'b1;
        gap(0, 5, "R2 first period 5");
        gap(0, 5, "R2 period 5");
        gap(0, 5, "R2 period 5 again");
        run0 = 1'b0; wc0(8'd0); run0 = 1'b1;
        gap(0, 256, "R2 threshold 0 gives 256");
        run0 = 1'b0; wc0(8'd1); run0 = 1'b1;
        gap(0, 1, "R2 threshold 1");
        gap(0, 1, "R2 threshold 1 again");

        // R9 stopped counter restarts from zero
        run0 = 1'b0; wc0(8'd10); run0 = 1'b1;
        step(6);
        run0 = 1'b0;
        cnt0 = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (irq0) cnt0++;
        end
        push("R9 no irq while stopped", 0); pop_cmp(cnt0);
        run0 = 1'b1;
        gap(0, 10, "R9 full period after restart");

        // R1 mode write ignored while running
        mode_in = 2'b01; mode_wr = 1'b1;
        @(negedge clk);
        mode_wr = 1'b0;
        meas(0, 1'b1, n);
        gap(0, 10, "R1 split mode kept while running");

        // R3 and R10 chained counter 1, output toggles
        run0 = 1'b0; run1 = 1'b0;
        step(1);
        ffc(2'b10, 0, "R7 clear before chain");
        wc0(8'd3); wc1(8'd4);
        chain1 = 1'b1; run0 = 1'b1; run1 = 1'b1;
        gap(1, 12, "R3 chained period 12");
        push("R10 tout toggled high", 1); pop_cmp(int'(tout));
        gap(1, 12, "R3 chained period 12 again");
        push("R10 tout toggled low", 0); pop_cmp(int'(tout));

        // R4 16-bit mode
        run0 = 1'b0; run1 = 1'b0; chain1 = 1'b0;
        set_mode(2'b01);
        wc0(8'd2); wc1(8'd1);
        run0 = 1'b1;
        for (int k = 0; k < 2; k++) begin
            cnt0 = 0; n = 0;
            do begin
                @(negedge clk);
                n++;
                if (irq0) cnt0++;
            end while (!irq1 && n < 1000);
            push("R4 16-bit period 258", 258); pop_cmp(n);
            push("R4 irq0 silent", 0); pop_cmp(cnt0);
        end

        // R5 pulse generator
        run0 = 1'b0;
        set_mode(2'b10);
        wc0(8'd3); wc1(8'd8);
        ffc(2'b10, 0, "R7 clear before pulse");
        run0 = 1'b1;
        cnt0 = 0;
        fork
            begin
                gap(2, 3, "R5 rise at threshold 0");
                gap(2, 5, "R5 fall at threshold 1");
                gap(2, 3, "R5 rise next period");
                gap(0, 5, "R5 irq0 at threshold 1");
            end
            begin
                for (int i = 0; i < 18; i++) begin
                    @(negedge clk);
                    if (irq1) cnt0++;
                end
            end
        join
        push("R5 irq1 silent", 0); pop_cmp(cnt0);

        // R6 PWM
        run0 = 1'b0;
        set_mode(2'b11);
        wc0(8'd64);
        ffc(2'b10, 0, "R7 clear before pwm");
        run0 = 1'b1;
        gap(2, 256, "R6 first wrap raises output");
        gap(2, 64, "R6 high time 64");
        gap(2, 192, "R6 low time 192");

        // R8 deferred and immediate threshold loads
        dbuf_en = 1'b1;
        wc0(8'd128);
        gap(2, 63, "R8 deferred write keeps old threshold");
        gap(2, 192, "R8 low time before copy");
        gap(2, 128, "R8 copied threshold at wrap");
        gap(2, 128, "R8 low time after copy");
        dbuf_en = 1'b0;
        wc0(8'd32);
        gap(2, 31, "R8 immediate write");

        // R7 commands
        run0 = 1'b0;
        set_mode(2'b00);
        ffc(2'b01, 1, "R7 set");
        ffc(2'b10, 0, "R7 clear");
        ffc(2'b00, 1, "R7 invert");
        ffc(2'b11, 1, "R7 no action");
        ffc(2'b00, 0, "R7 invert back");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule